// File: doc/BRIEF.md
# PWM Period to Timer Configuration Calculator

This block converts a requested PWM period, given in microseconds, into the settings a 16-bit PWM timer needs: a clock divider selection, a 4-bit waveform mode code and a TOP value for the counter. A request also carries the PWM flavour and a flag that picks which register holds TOP. The core clock rate in MHz is a build parameter.

The block works through the request sequentially. It latches the inputs on a start strobe and clamps the period so the tick product cannot overflow. It scales the period to ticks, halving them for the two centre-aligned flavours. It then walks the divider ladder one rung per cycle and keeps the largest divider that still leaves at least 8 bits of counter resolution. Finally it forms the mode code, and swaps in one of the fixed-width 8, 9 or 10 bit modes when the final TOP lands exactly on such a width limit. A one-cycle done strobe marks the moment the outputs carry a new result. The outputs then hold until the next result.

Top module: `pwm_period_cfg`

## Requirements
- R1: While reset is active and after it ends, `clockSelO`, `modeO` and `topO` are zero and `doneO` is low until the first result.
- R2: Inputs are sampled only on the edge where `startI` is high while the block is idle. `doneO` goes high for exactly one cycle, 7 clock edges after that edge. A start raised during a calculation is ignored, and input changes after the sampling edge have no effect.
- R3: Before scaling, the period is limited to floor((2^32 - 1) / CLK_MHZ). A larger request gives the same result as that limit.
- R4: Ticks are CLK_MHZ times the period. They are halved (shift right by one) unless `kindI` is 0 (fast). `kindI` codes: 0 fast, 1 phase-correct, 2 phase-and-frequency-correct, 3 treated as 2.
- R5: The divider search works on ticks T. If T <= 2040, code 1 (divide by 1) is chosen. Otherwise T = T>>3, and code 2 (divide by 8) is chosen if T <= 2040. Otherwise T = T>>3, and code 3 (divide by 64) is chosen if T <= 1020. Otherwise T = T>>2, and code 4 (divide by 256) is chosen if T <= 1020. Otherwise T = T>>2 and code 5 (divide by 1024) is chosen.
- R6: `topO` equals the ticks after the shifts applied up to the chosen divider.
- R7: For divider code 5, a TOP above 0xFFFF is limited to 0xFFFF.
- R8: The default mode code is 15 (fast), 11 (phase-correct) or 9 (phase-and-frequency-correct) when `useCmpAI` is 1, and 14, 10 or 8 when it is 0.
- R9: For fast and phase-correct requests, a final TOP of 0xFF, 0x1FF or 0x3FF replaces the mode with 5, 6, 7 (fast) or 1, 2, 3 (phase-correct), whatever `useCmpAI` is.
- R10: For phase-and-frequency-correct requests (kind 2 or 3) the fixed-width substitution never happens.
- R11: Between results, the three configuration outputs hold their values and `doneO` stays low, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start a calculation (sampled when idle) |
| periodI | input | 32 | Requested period in microseconds |
| kindI | input | 2 | PWM flavour: 0 fast, 1 phase-correct, 2/3 phase-and-frequency-correct |
| useCmpAI | input | 1 | 1: compare register A holds TOP, 0: capture register holds TOP |
| clockSelO | output | 3 | Divider code 1..5 |
| modeO | output | 4 | Waveform mode code |
| topO | output | 16 | Counter TOP value |
| doneO | output | 1 | One-cycle pulse when a new result is present |

## Verification
The bench builds the block with CLK_MHZ = 16, a 16-bit TOP and the 255-tick resolution floor. With a 16x scale, a period of 2^28 microseconds would wrap the tick product to zero, so the period limit changes the visible result. Periods just above the divide-by-8 threshold land exactly on 0xFF and 0x1FF after the divide-by-64 shift. Periods near 65500 reach the 10-bit fixed mode through the divide-by-1024 rung. The scale also puts every divider rung and its threshold edge within a handful of small periods.

// File: rtl/pwm_period_cfg_pkg.sv
package pwm_period_cfg_pkg;

  localparam int NUM_STAGES      = 5;
  localparam int STAGE_W         = 3;
  localparam int LATENCY         = NUM_STAGES + 2;
  localparam int NUM_FIXED       = 3;
  localparam int FIXED_BASE_BITS = 8;

  localparam logic [1:0] KIND_FAST  = 2'd0;
  localparam logic [1:0] KIND_PHASE = 2'd1;

  localparam logic [3:0] MODE_PHASE_FIX0 = 4'd1;
  localparam logic [3:0] MODE_FAST_FIX0  = 4'd5;
  localparam logic [3:0] MODE_PF_CAP     = 4'd8;
  localparam logic [3:0] MODE_PF_CMPA    = 4'd9;
  localparam logic [3:0] MODE_PH_CAP     = 4'd10;
  localparam logic [3:0] MODE_PH_CMPA    = 4'd11;
  localparam logic [3:0] MODE_FAST_CAP   = 4'd14;
  localparam logic [3:0] MODE_FAST_CMPA  = 4'd15;

  typedef struct packed {
    logic               load;
    logic               scale;
    logic               step;
    logic [STAGE_W-1:0] stage;
    logic               finish;
  } ctlStrobes_t;

  function automatic int stageShift(input int s);
    case (s)
      0:       return 0;
      1, 2:    return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int stageLimit(input int s, input int minRes);
    if (s < 2) return minRes * 8;
    return minRes * 4;
  endfunction

endpackage

// File: rtl/pwm_period_cfg_ctrl.sv
module pwm_period_cfg_ctrl
  import pwm_period_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startI,
  output ctlStrobes_t ctlO,
  output logic        doneO
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCALE, ST_SEARCH, ST_FINISH} state_e;

  state_e             stateQ;
  logic [STAGE_W-1:0] stageQ;

  always_comb begin
    ctlO.load   = (stateQ == ST_IDLE) && startI;
    ctlO.scale  = (stateQ == ST_SCALE);
    ctlO.step   = (stateQ == ST_SEARCH);
    ctlO.stage  = stageQ;
    ctlO.finish = (stateQ == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      stageQ <= '0;
      doneO  <= 1'b0;
    end else begin
      doneO <= (stateQ == ST_FINISH);
      case (stateQ)
        ST_IDLE:   if (startI) stateQ <= ST_SCALE;
        ST_SCALE: begin
          stateQ <= ST_SEARCH;
          stageQ <= '0;
        end
        ST_SEARCH: begin
          if (stageQ == STAGE_W'(NUM_STAGES - 1)) stateQ <= ST_FINISH;
          else stageQ <= stageQ + 1'b1;
        end
        default:   stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwm_period_cfg_datapath.sv
module pwm_period_cfg_datapath
  import pwm_period_cfg_pkg::*;
#(
  parameter int CLK_MHZ  = 16,
  parameter int PERIOD_W = 32,
  parameter int TOP_W    = 16,
  parameter int MIN_RES  = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrobes_t         ctlI,
  input  logic [PERIOD_W-1:0] periodI,
  input  logic [1:0]          kindI,
  input  logic                useCmpAI,
  output logic [2:0]          clockSelO,
  output logic [3:0]          modeO,
  output logic [TOP_W-1:0]    topO
);

  localparam int TICK_W = PERIOD_W;
  localparam logic [PERIOD_W-1:0] ALL_ONES   = '1;
  localparam logic [PERIOD_W-1:0] CLK_W      = PERIOD_W'(CLK_MHZ);
  localparam logic [PERIOD_W-1:0] MAX_PERIOD = ALL_ONES / CLK_W;
  localparam logic [TICK_W-1:0]   TICK_MAX   = TICK_W'((64'd1 << TOP_W) - 64'd1);

  logic [PERIOD_W-1:0] periodQ;
  logic [1:0]          kindQ;
  logic                useCmpAQ;
  logic [TICK_W-1:0]   ticksQ;
  logic                decidedQ;
  logic [2:0]          clkSelQ;

  logic [TICK_W-1:0]   product;
  logic [TICK_W-1:0]   shifted;
  logic [TICK_W-1:0]   limitVal;
  logic [TICK_W-1:0]   capped;
  logic                lastStage;
  logic [NUM_FIXED-1:0] fixedHit;
  logic                substAllowed;
  logic [3:0]          modeNext;

  // Scaling and one rung of the divider ladder
  always_comb begin
    product   = periodQ * CLK_W;
    shifted   = ticksQ >> stageShift(int'(ctlI.stage));
    limitVal  = TICK_W'(stageLimit(int'(ctlI.stage), MIN_RES));
    capped    = (shifted > TICK_MAX) ? TICK_MAX : shifted;
    lastStage = (ctlI.stage == STAGE_W'(NUM_STAGES - 1));
  end

  // Width-limit detectors, one per fixed mode
  for (genvar w = 0; w < NUM_FIXED; w++) begin : g_fixed
    assign fixedHit[w] = (ticksQ == TICK_W'((64'd1 << (FIXED_BASE_BITS + w)) - 64'd1));
  end

  always_comb begin
    substAllowed = (kindQ == KIND_FAST) || (kindQ == KIND_PHASE);
    case (kindQ)
      KIND_FAST:  modeNext = useCmpAQ ? MODE_FAST_CMPA : MODE_FAST_CAP;
      KIND_PHASE: modeNext = useCmpAQ ? MODE_PH_CMPA   : MODE_PH_CAP;
      default:    modeNext = useCmpAQ ? MODE_PF_CMPA   : MODE_PF_CAP;
    endcase
    for (int w = 0; w < NUM_FIXED; w++) begin
      if (substAllowed && fixedHit[w]) begin
        modeNext = ((kindQ == KIND_FAST) ? MODE_FAST_FIX0 : MODE_PHASE_FIX0) + 4'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodQ   <= '0;
      kindQ     <= '0;
      useCmpAQ  <= 1'b0;
      ticksQ    <= '0;
      decidedQ  <= 1'b0;
      clkSelQ   <= '0;
      clockSelO <= '0;
      modeO     <= '0;
      topO      <= '0;
    end else begin
      if (ctlI.load) begin
        periodQ  <= (periodI > MAX_PERIOD) ? MAX_PERIOD : periodI;
        kindQ    <= kindI;
        useCmpAQ <= useCmpAI;
      end
      if (ctlI.scale) begin
        ticksQ   <= (kindQ == KIND_FAST) ? product : (product >> 1);
        decidedQ <= 1'b0;
        clkSelQ  <= '0;
      end
      if (ctlI.step && !decidedQ) begin
        decidedQ <= lastStage || (shifted <= limitVal);
        if (lastStage) begin
          ticksQ  <= capped;
          clkSelQ <= 3'(NUM_STAGES);
        end else begin
          ticksQ  <= shifted;
          if (shifted <= limitVal) clkSelQ <= 3'(ctlI.stage) + 3'd1;
        end
      end
      if (ctlI.finish) begin
        clockSelO <= clkSelQ;
        modeO     <= modeNext;
        topO      <= ticksQ[TOP_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pwm_period_cfg.sv
module pwm_period_cfg
  import pwm_period_cfg_pkg::*;
#(
  parameter int CLK_MHZ  = 16,
  parameter int PERIOD_W = 32,
  parameter int TOP_W    = 16,
  parameter int MIN_RES  = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startI,
  input  logic [PERIOD_W-1:0] periodI,
  input  logic [1:0]          kindI,
  input  logic                useCmpAI,
  output logic [2:0]          clockSelO,
  output logic [3:0]          modeO,
  output logic [TOP_W-1:0]    topO,
  output logic                doneO
);

  ctlStrobes_t ctl;

  pwm_period_cfg_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .startI (startI),
    .ctlO   (ctl),
    .doneO  (doneO)
  );

  pwm_period_cfg_datapath #(
    .CLK_MHZ  (CLK_MHZ),
    .PERIOD_W (PERIOD_W),
    .TOP_W    (TOP_W),
    .MIN_RES  (MIN_RES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctlI      (ctl),
    .periodI   (periodI),
    .kindI     (kindI),
    .useCmpAI  (useCmpAI),
    .clockSelO (clockSelO),
    .modeO     (modeO),
    .topO      (topO)
  );

endmodule

// File: rtl/pwm_period_cfg_chk.sv
module pwm_period_cfg_chk
  import pwm_period_cfg_pkg::*;
#(
  parameter int TOP_W   = 16,
  parameter int MIN_RES = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startI,
  input logic             doneI,
  input logic [2:0]       clockSelI,
  input logic [3:0]       modeI,
  input logic [TOP_W-1:0] topI
);

  localparam logic [4:0] DUE = 5'(LATENCY + 1);

  logic [4:0] runCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runCnt <= '0;
    else if (runCnt == '0 || runCnt == DUE) runCnt <= startI ? 5'd1 : 5'd0;
    else runCnt <= runCnt + 5'd1;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doneI |=> !doneI);

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doneI |-> (runCnt == DUE));

  assert_done_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (runCnt == DUE) |-> doneI);

  assert_clksel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doneI |-> (clockSelI >= 3'd1 && clockSelI <= 3'd5));

  assert_top_resolution_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (doneI && clockSelI >= 3'd1 && clockSelI <= 3'd2) |-> (topI <= TOP_W'(MIN_RES * 8)));

  assert_top_resolution_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (doneI && clockSelI >= 3'd3 && clockSelI <= 3'd4) |-> (topI <= TOP_W'(MIN_RES * 4)));

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneI |-> (modeI != 4'd0 && modeI != 4'd4 && modeI != 4'd12 && modeI != 4'd13));

  assert_fixed8_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (doneI && (modeI == 4'd1 || modeI == 4'd5)) |-> (topI == TOP_W'(255)));

  assert_fixed9_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (doneI && (modeI == 4'd2 || modeI == 4'd6)) |-> (topI == TOP_W'(511)));

  assert_fixed10_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (doneI && (modeI == 4'd3 || modeI == 4'd7)) |-> (topI == TOP_W'(1023)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !doneI |-> $stable({clockSelI, modeI, topI}));

endmodule

bind pwm_period_cfg pwm_period_cfg_chk #(
  .TOP_W   (TOP_W),
  .MIN_RES (MIN_RES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startI    (startI),
  .doneI     (doneO),
  .clockSelI (clockSelO),
  .modeI     (modeO),
  .topI      (topO)
);

// File: tb/tb_pwm_period_cfg.sv
`timescale 1ns/1ps
module tb_pwm_period_cfg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startI = 1'b0;
  logic [31:0] periodI = '0;
  logic [1:0]  kindI = '0;
  logic        useCmpAI = 1'b0;
  logic [2:0]  clockSelO;
  logic [3:0]  modeO;
  logic [15:0] topO;
  logic        doneO;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pwm_period_cfg #(.CLK_MHZ(16), .PERIOD_W(32), .TOP_W(16), .MIN_RES(255)) dut (
    .clk(clk), .rst_n(rst_n), .startI(startI), .periodI(periodI), .kindI(kindI),
    .useCmpAI(useCmpAI), .clockSelO(clockSelO), .modeO(modeO), .topO(topO), .doneO(doneO)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitDone(inout int n);
    while (!doneO && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  // One request; checks latency, pulse width and all three outputs
  task automatic runCalc(input [31:0] p, input [1:0] k, input bit a,
                         input [2:0] eClk, input [3:0] eMode, input [15:0] eTop,
                         input string tag);
    int n;
    @(negedge clk);
    periodI = p; kindI = k; useCmpAI = a; startI = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startI = 1'b0;
    n = 0;
    waitDone(n);
    chk(n == 7, {tag, " R2 latency"}, n, 7);
    chk(clockSelO == eClk, {tag, " clockSel"}, clockSelO, eClk);
    chk(modeO == eMode, {tag, " mode"}, modeO, eMode);
    chk(topO == eTop, {tag, " top"}, topO, eTop);
    @(negedge clk);
    chk(doneO == 1'b0, {tag, " R2 done one cycle"}, doneO, 0);
  endtask

  task automatic testReset();
    chk(clockSelO == 0 && modeO == 0 && topO == 0, "R1 outputs in reset", {clockSelO, modeO, topO}, 0);
    chk(doneO == 0, "R1 done in reset", doneO, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(clockSelO == 0 && modeO == 0 && topO == 0, "R1 outputs after reset", {clockSelO, modeO, topO}, 0);
    chk(doneO == 0, "R1 done after reset", doneO, 0);
  endtask

  task automatic testBusyIgnored();
    int n;
    @(negedge clk);
    periodI = 32'd100; kindI = 2'd0; useCmpAI = 1'b1; startI = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startI = 1'b0; periodI = 32'd5000; kindI = 2'd1; useCmpAI = 1'b0;
    @(negedge clk);
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    n = 2;
    waitDone(n);
    chk(n == 7, "R2 busy start latency", n, 7);
    chk(clockSelO == 3'd1 && modeO == 4'd15 && topO == 16'd1600,
        "R2 first request kept", {clockSelO, modeO, topO}, {3'd1, 4'd15, 16'd1600});
    n = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (doneO) n++;
    end
    chk(n == 0, "R2 ignored start gives no second result", n, 0);
  endtask

  task automatic testHold();
    int changes = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      periodI = 32'd7 * i; kindI = 2'(i); useCmpAI = i[0];
      if (doneO || clockSelO != 3'd1 || modeO != 4'd15 || topO != 16'd1600) changes++;
    end
    chk(changes == 0, "R11 outputs hold without start", changes, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 run did not finish actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    // R4 R5 R8: divide-by-1 rung, both TOP sources
    runCalc(32'd100, 2'd0, 1'b1, 3'd1, 4'd15, 16'd1600, "R5 R8 fast cmpA");
    runCalc(32'd100, 2'd0, 1'b0, 3'd1, 4'd14, 16'd1600, "R8 fast capture");
    runCalc(32'd127, 2'd0, 1'b1, 3'd1, 4'd15, 16'd2032, "R5 div1 edge");
    runCalc(32'd128, 2'd0, 1'b1, 3'd2, 4'd15, 16'd256,  "R5 R6 div8 edge");
    runCalc(32'd200, 2'd1, 1'b0, 3'd1, 4'd10, 16'd1600, "R4 phase halved");
    runCalc(32'd200, 2'd2, 1'b1, 3'd1, 4'd9,  16'd1600, "R4 R8 phfreq");
    runCalc(32'd1500, 2'd0, 1'b1, 3'd3, 4'd15, 16'd375, "R5 R6 div64");
    runCalc(32'd5000, 2'd0, 1'b1, 3'd4, 4'd15, 16'd312, "R5 R6 div256");
    runCalc(32'd100000, 2'd0, 1'b1, 3'd5, 4'd15, 16'd1562, "R5 R6 div1024");
    runCalc(32'd10000000, 2'd0, 1'b1, 3'd5, 4'd15, 16'hFFFF, "R7 top limit");
    runCalc(32'h1000_0000, 2'd0, 1'b1, 3'd5, 4'd15, 16'hFFFF, "R3 period limit");
    runCalc(32'hFFFF_FFFF, 2'd0, 1'b0, 3'd5, 4'd14, 16'hFFFF, "R3 max period");
    runCalc(32'd1021, 2'd0, 1'b1, 3'd3, 4'd5, 16'd255,  "R9 fast 8bit");
    runCalc(32'd2044, 2'd0, 1'b0, 3'd3, 4'd6, 16'd511,  "R9 fast 9bit");
    runCalc(32'd65500, 2'd0, 1'b1, 3'd5, 4'd7, 16'd1023, "R9 fast 10bit");
    runCalc(32'd2044, 2'd1, 1'b1, 3'd3, 4'd1, 16'd255,  "R9 phase 8bit");
    runCalc(32'd511, 2'd1, 1'b0, 3'd2, 4'd2, 16'd511,   "R9 phase 9bit");
    runCalc(32'd1023, 2'd1, 1'b1, 3'd2, 4'd3, 16'd1023, "R9 phase 10bit");
    runCalc(32'd2044, 2'd2, 1'b0, 3'd3, 4'd8, 16'd255,  "R10 phfreq no subst");
    runCalc(32'd2044, 2'd3, 1'b1, 3'd3, 4'd9, 16'd255,  "R10 R4 unknown kind");
    testBusyIgnored();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule